// File: doc/BRIEF.md
# UART Host Register Block

This block is the host-facing register file of a small serial port. A host talks to it over a 32-bit request/acknowledge register bus. The host writes outgoing characters into a 16-entry transmit queue and reads incoming characters out of a receive queue. A write-only control word sets an interrupt-enable level and can empty either queue at once.

The serial side uses two byte streams with valid/ready handshakes. On the transmit stream the block is the source. `tx_valid` is high while the transmit queue holds a character. A character leaves the queue on any cycle where `tx_valid` and `tx_ready` are both high, and the source must hold `tx_data` until then. On the receive stream the block is the sink. `rx_ready` is low while the receive queue is full. A character is taken only on a cycle where `rx_valid` and `rx_ready` are both high, so a full queue pushes back on the shifter instead of losing data.

Characters sit right-justified in the bus word and all higher bits read as zero. Baud timing, shifters, status and interrupt edge logic live elsewhere. This block only exports the enable level.

Top module: `uart_host_regs`

## Requirements
- R1: A write to offset 0x4 pushes the low DATA_W bits of `wdata` into the transmit queue, which holds up to 16 characters. `tx_valid` is high while the queue is not empty, and `tx_data` is the oldest character. A character is removed on each cycle with `tx_valid` and `tx_ready` both high, in first-in first-out order.
- R2: A write to offset 0x4 while the transmit queue holds 16 characters is acknowledged and its data is discarded.
- R3: A read of offset 0x0 with a non-empty receive queue returns the oldest received character in bits DATA_W-1:0, with all higher bits zero, and removes it.
- R4: A read of offset 0x0 with an empty receive queue is acknowledged with zero data and removes nothing.
- R5: Reads of offsets 0x4, 0x8 and 0xC are acknowledged with a zero data word.
- R6: Each cycle with `req` high produces exactly one `ack` pulse in the following cycle, with `rdata` valid in that cycle. `ack` is never high without a request in the previous cycle.
- R7: Every write to offset 0xC loads bit 4 of `wdata` into the interrupt-enable level on `irq_en`. The level holds until the next write to 0xC, and bits 2, 3 and 5 to 31 have no effect.
- R8: A write to 0xC with bit 0 set empties the transmit queue, with effect by the acknowledge cycle. The bit is not stored, so the queue accepts new characters right after.
- R9: A write to 0xC with bit 1 set empties the receive queue, with effect by the acknowledge cycle. The bit is not stored.
- R10: If a receive flush and a receive-stream handshake fall in the same cycle, the flush wins and the offered character is discarded.
- R11: `rx_ready` is low exactly while the receive queue holds 16 characters. A character offered while `rx_ready` is low is not taken, and the queued characters are kept.
- R12: After reset `ack`, `rdata`, `irq_en` and `tx_valid` are 0, `rx_ready` is 1, and both queues are empty.
- R13: Writes to offsets 0x0 and 0x8 change no queue and no control state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Bus request, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte offset; bits 3:2 select the word |
| wdata | input | 32 | Write data |
| ack | output | 1 | Acknowledge, one cycle after the request |
| rdata | output | 32 | Read data, valid while ack is high |
| tx_valid | output | 1 | Transmit queue holds a character |
| tx_ready | input | 1 | Transmit consumer takes the character |
| tx_data | output | DATA_W | Oldest transmit character |
| rx_valid | input | 1 | Receive producer offers a character |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | DATA_W | Offered receive character |
| irq_en | output | 1 | Stored interrupt-enable level |

## Verification
The bench fills the transmit queue to 16 and writes once more. A design that overwrote or wrapped would show the extra byte or lose the first one when the queue drains. It fills the receive queue and keeps offering a character to check back-pressure, and it reads an empty receive queue. A wrong design would hand out stale data there, or underflow and return garbage on the next read. It fires a receive flush in the same cycle as a stream push. It also checks that flush bits are not stored and that writes to write-ignored offsets change nothing. A design that got either wrong would drop later characters or corrupt a queue.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    SEL_RXQ  = 2'd0,
    SEL_TXQ  = 2'd1,
    SEL_NONE = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;

  localparam int CTL_TX_FLUSH_BIT = 0;
  localparam int CTL_RX_FLUSH_BIT = 1;
  localparam int CTL_IEN_BIT      = 4;
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(cnt));
  p_empty_no_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);
  // flush covers R8 (transmit) and R9 (receive)
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic ien_bit,
  input  logic txf_bit,
  input  logic rxf_bit,
  output logic ien,
  output logic flush_tx,
  output logic flush_rx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ien <= 1'b0;
    else if (wr) ien <= ien_bit;
  end

  assign flush_tx = wr && txf_bit;
  assign flush_rx = wr && rxf_bit;

  p_ien_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ien));
  p_ien_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ien == $past(ien_bit)));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic              ack,
  output logic [BUS_W-1:0]  rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              irq_en
);
  reg_sel_e          sel;
  logic              wr_tx, rd_rx, wr_ctl, rd_zero;
  logic              flush_tx, flush_rx;
  logic              tx_empty, tx_full_unused, rx_empty, rx_full;
  logic [DATA_W-1:0] rx_head;
  logic [BUS_W-1:0]  rdata_d;
  logic              unused_bits;

  assign sel     = reg_sel_e'(addr[3:2]);
  assign wr_tx   = req && we && (sel == SEL_TXQ);
  assign wr_ctl  = req && we && (sel == SEL_CTL);
  assign rd_rx   = req && !we && (sel == SEL_RXQ);
  assign rd_zero = req && !we && (sel != SEL_RXQ);
  assign unused_bits = ^{addr[1:0], wdata, tx_full_unused};

  uart_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_ctl),
    .ien_bit  (wdata[CTL_IEN_BIT]),
    .txf_bit  (wdata[CTL_TX_FLUSH_BIT]),
    .rxf_bit  (wdata[CTL_RX_FLUSH_BIT]),
    .ien      (irq_en),
    .flush_tx (flush_tx),
    .flush_rx (flush_rx)
  );

  char_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_tx),
    .push      (wr_tx),
    .push_data (wdata[DATA_W-1:0]),
    .pop       (tx_valid && tx_ready),
    .head      (tx_data),
    .empty     (tx_empty),
    .full      (tx_full_unused)
  );

  char_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_rx),
    .push      (rx_valid && rx_ready),
    .push_data (rx_data),
    .pop       (rd_rx),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_comb begin
    rdata_d = '0;
    if (rd_rx && !rx_empty) rdata_d[DATA_W-1:0] = rx_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      rdata <= rdata_d;
    end
  end

  p_ack_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);
  p_ack_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));
  p_wo_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |=> (rdata == '0));
  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_empty) |=> (rdata == '0));

  generate
    if (DATA_W < BUS_W) begin : g_upper
      p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (rdata[BUS_W-1:DATA_W] == '0));
    end
  endgenerate
endmodule

// File: tb/uart_host_regs_test.sv
module uart_host_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        irq_en;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  uart_host_regs uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .irq_en(irq_en)
  );

  // entry: we, addr, wdata, expected rdata, requirement number
  localparam int NV = 10;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 4'h4, 32'h0000_00A5, 32'h0, 4'd1},
    {1'b1, 4'h4, 32'hFFFF_FF3C, 32'h0, 4'd1},
    {1'b0, 4'h4, 32'h0,         32'h0, 4'd5},
    {1'b0, 4'hC, 32'h0,         32'h0, 4'd5},
    {1'b0, 4'h8, 32'h0,         32'h0, 4'd5},
    {1'b0, 4'h0, 32'h0,         32'h0, 4'd4},
    {1'b1, 4'hC, 32'hFFFF_FF10, 32'h0, 4'd7},
    {1'b1, 4'h8, 32'h0000_0003, 32'h0, 4'd13},
    {1'b1, 4'h0, 32'h0000_0003, 32'h0, 4'd13},
    {1'b0, 4'hC, 32'h0,         32'h0, 4'd5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk({tag, " ack"}, 32'(ack), 32'd1);
    if (!w) chk(tag, rdata, exp);
    @(negedge clk);
    chk("R6 ack single", 32'(ack), 32'd0);
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk({tag, " valid"}, 32'(tx_valid), 32'd1);
    chk(tag, 32'(tx_data), 32'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ack", 32'(ack), 32'd0);
    chk("R12 rdata", rdata, 32'd0);
    chk("R12 irq_en", 32'(irq_en), 32'd0);
    chk("R12 tx_valid", 32'(tx_valid), 32'd0);
    chk("R12 rx_ready", 32'(rx_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][72], VEC[i][71:68], VEC[i][67:36], VEC[i][35:4],
          $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end
    chk("R7 irq_en set, reserved ignored", 32'(irq_en), 32'd1);
    // R13: writes at 0x0/0x8 did not flush transmit queue
    tx_take(8'hA5, "R1 first");
    tx_take(8'h3C, "R1 second");
    @(negedge clk);
    chk("R1 drained", 32'(tx_valid), 32'd0);

    // R2 fill transmit queue and overflow
    for (int i = 0; i < 16; i++) bus(1'b1, 4'h4, 32'(i + 8'h40), 32'h0, "R2 fill");
    bus(1'b1, 4'h4, 32'hEE, 32'h0, "R2 overflow");
    for (int i = 0; i < 16; i++) tx_take(8'(i + 8'h40), "R2 order");
    @(negedge clk);
    chk("R2 extra dropped", 32'(tx_valid), 32'd0);

    // R3 receive path
    rx_push(8'h11); rx_push(8'hF2); rx_push(8'h33);
    bus(1'b0, 4'h0, 32'h0, 32'h11, "R3 rx0");
    bus(1'b0, 4'h0, 32'h0, 32'hF2, "R3 rx1");
    bus(1'b0, 4'h0, 32'h0, 32'h33, "R3 rx2");
    bus(1'b0, 4'h0, 32'h0, 32'h0, "R4 empty read");

    // R11 back-pressure
    for (int i = 0; i < 16; i++) rx_push(8'(i + 8'h80));
    @(negedge clk);
    chk("R11 rx_ready low when full", 32'(rx_ready), 32'd0);
    rx_push(8'h5A);
    for (int i = 0; i < 16; i++) bus(1'b0, 4'h0, 32'h0, 32'(i + 8'h80), "R11 kept");
    bus(1'b0, 4'h0, 32'h0, 32'h0, "R11 offered char not taken");

    // R8 transmit flush, not stored
    bus(1'b1, 4'h4, 32'h01, 32'h0, "R8 prep");
    bus(1'b1, 4'h4, 32'h02, 32'h0, "R8 prep");
    bus(1'b1, 4'hC, 32'h11, 32'h0, "R8 flush");
    chk("R8 tx empty after flush", 32'(tx_valid), 32'd0);
    chk("R7 ien kept with flush", 32'(irq_en), 32'd1);
    bus(1'b1, 4'h4, 32'h77, 32'h0, "R8 after");
    tx_take(8'h77, "R8 push after flush");

    // R9 receive flush
    rx_push(8'hA1); rx_push(8'hA2);
    bus(1'b1, 4'hC, 32'h12, 32'h0, "R9 flush");
    bus(1'b0, 4'h0, 32'h0, 32'h0, "R9 rx empty after flush");
    rx_push(8'hA3);
    bus(1'b0, 4'h0, 32'h0, 32'hA3, "R9 not stored");

    // R10 flush and push in the same cycle
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'hC; wdata = 32'h02;
    rx_valid = 1'b1; rx_data = 8'h99;
    @(negedge clk);
    req = 1'b0; we = 1'b0; rx_valid = 1'b0;
    chk("R10 ack", 32'(ack), 32'd1);
    chk("R7 ien cleared", 32'(irq_en), 32'd0);
    bus(1'b0, 4'h0, 32'h0, 32'h0, "R10 pushed char discarded");

    // R13 ignored writes keep control state
    bus(1'b1, 4'hC, 32'h10, 32'h0, "R13 prep");
    bus(1'b1, 4'h8, 32'h00, 32'h0, "R13 write 0x8");
    bus(1'b1, 4'h0, 32'h00, 32'h0, "R13 write 0x0");
    chk("R13 irq_en unchanged", 32'(irq_en), 32'd1);
    chk("R13 tx untouched", 32'(tx_valid), 32'd0);
    bus(1'b0, 4'h0, 32'h0, 32'h0, "R13 rx untouched");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule